// File: doc/BRIEF.md
# Test-access instruction and data register core

This block sits behind a test-access-port state machine in a small programmable-logic device. The state machine runs elsewhere. It hands this block one strobe each for the capture, shift and update steps of both the instruction path and the data path. The block holds the instruction register and decodes it. From the decoded instruction it picks one data register to sit between the serial input and the serial output, and it drives the serial output on the falling test-clock edge.

The opcode map is the device's own. Several private opcodes share the one-bit bypass path. The in-system-configuration opcodes reach three registers of different lengths: an enable register, a configuration/address register and a data register. Each of these three has a parallel hold register, which is loaded on Update-DR and read back on Capture-DR. The flash-programming opcodes do no work inside the block. Each one only produces a single-cycle strobe with a 3-bit operation code, issued on Update-DR. The boundary chain is external: its serial output comes in as a port, and the block shares the data strobes with it.

Top module: `jtag_ir_dr_core`

## Requirements
- R1: While trst_n is low, the instruction register resets to 0xFE (identification), tdo and tdo_en are 0, flash_go is 0 and all three hold registers are 0. A data scan straight after reset therefore returns the identification word.
- R2: On Capture-IR the instruction shift register loads {3'b000, isc_status[2:0], 2'b01}. Bit 0 leaves first.
- R3: The instruction register changes only on Update-IR, taking the 8 bits shifted in, LSB first. The opcodes are: 0x00 pin drive, 0x01 pin sample, 0x02 core test, 0xE8 config enable, 0xEA program, 0xEB program-increment, 0xEC erase, 0xED bulk erase, 0xEE verify, 0xEF verify-increment, 0xF0 reload, 0xFC outputs off, 0xFD user word, 0xFE identification, 0xFF bypass.
- R4: Opcodes 0xFF, 0xF0 and 0xFC, and every opcode not listed in R3, select a 1-bit bypass register. It captures 0, so tdi reaches tdo one shift later.
- R5: Opcode 0xFE selects a 32-bit register that captures 0x29508093.
- R6: Opcode 0xFD selects a 32-bit register that captures usercode_i.
- R7: Opcode 0xE8 selects a 12-bit register. Opcodes 0xEA, 0xEC, 0xED and 0xEE select a 27-bit register. Opcodes 0xEB and 0xEF select a 10-bit register. Each captures its hold register, and Update-DR copies the shifted bits into that hold register (isc_en_q, isc_cfg_q, isc_dat_q). No other event changes a hold register.
- R8: Update-DR under 0xEC, 0xED, 0xEA, 0xEB, 0xEE or 0xEF raises flash_go for exactly the following cycle. flash_op then reads 0, 1, 2, 3, 4 or 5 respectively. No other Update-DR raises flash_go.
- R9: The mode outputs decode the current instruction: pins_drive for 0x00, core_drive for 0x02, pins_hiz for 0xFC and cfg_reload for 0xF0. At most one of them is high.
- R10: Opcodes 0x00, 0x01 and 0x02 raise bsr_sel and route bsr_so to tdo.
- R11: tdo and tdo_en change only on the falling edge of tck. tdo_en is high only after a falling edge that sees shift_ir or shift_dr, and tdo is 0 whenever tdo_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| update_ir | input | 1 | Update-IR state strobe |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| isc_status | input | 3 | Status bits placed in the IR capture pattern |
| usercode_i | input | 32 | User word captured under 0xFD |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Serial output valid |
| bsr_sel | output | 1 | Boundary chain selected |
| pins_drive | output | 1 | Boundary cells drive the pins |
| core_drive | output | 1 | Boundary cells drive the core |
| pins_hiz | output | 1 | All device outputs disabled |
| cfg_reload | output | 1 | Configuration reload requested |
| flash_go | output | 1 | One-cycle flash operation strobe |
| flash_op | output | 3 | Flash operation code |
| isc_en_q | output | 12 | Config-enable hold register |
| isc_cfg_q | output | 27 | Configuration/address hold register |
| isc_dat_q | output | 10 | Configuration data hold register |

## Verification
A single Update-DR edge under a flash opcode does two jobs: it loads a hold register and it raises the flash strobe. A downstream flash sequencer must find the new address or data already in place when it sees flash_go. The bench scans a programming opcode, shifts a fresh random word, and in the cycle after Update-DR checks both flash_go with its code and the hold register against the shifted word. A later capture must then read that word back. Random opcodes, including unlisted ones, are mixed with directed scans so that this pairing occurs under every flash opcode.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
   localparam int IR_W = 8;

   localparam logic [IR_W-1:0] OP_PIN_DRIVE  = 8'h00;
   localparam logic [IR_W-1:0] OP_PIN_SAMPLE = 8'h01;
   localparam logic [IR_W-1:0] OP_CORE_TEST  = 8'h02;
   localparam logic [IR_W-1:0] OP_CFG_ENABLE = 8'hE8;
   localparam logic [IR_W-1:0] OP_PROG       = 8'hEA;
   localparam logic [IR_W-1:0] OP_PROG_INC   = 8'hEB;
   localparam logic [IR_W-1:0] OP_ERASE      = 8'hEC;
   localparam logic [IR_W-1:0] OP_BULK_ERASE = 8'hED;
   localparam logic [IR_W-1:0] OP_VERIFY     = 8'hEE;
   localparam logic [IR_W-1:0] OP_VERIFY_INC = 8'hEF;
   localparam logic [IR_W-1:0] OP_RELOAD     = 8'hF0;
   localparam logic [IR_W-1:0] OP_OUTS_OFF   = 8'hFC;
   localparam logic [IR_W-1:0] OP_USER_WORD  = 8'hFD;
   localparam logic [IR_W-1:0] OP_IDENT      = 8'hFE;
   localparam logic [IR_W-1:0] OP_BYPASS     = 8'hFF;

   typedef enum logic [2:0] {
      SEL_BYPASS, SEL_IDENT, SEL_USER, SEL_BOUNDARY,
      SEL_ISC_EN, SEL_ISC_CFG, SEL_ISC_DAT
   } dr_sel_e;

   typedef enum logic [2:0] {
      FOP_ERASE    = 3'd0,
      FOP_BULK     = 3'd1,
      FOP_PROG     = 3'd2,
      FOP_PROG_INC = 3'd3,
      FOP_VERIFY   = 3'd4,
      FOP_VER_INC  = 3'd5
   } flash_op_e;

   typedef struct packed {
      dr_sel_e   sel;
      logic      pins_drive;
      logic      core_drive;
      logic      out_hiz;
      logic      reload;
      logic      flash_ok;
      flash_op_e fop;
   } ir_dec_t;
endpackage

// File: rtl/jtag_scan_chain.sv
module jtag_scan_chain #(
   parameter int W = 8
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         cap,
   input  logic         shf,
   input  logic         tdi,
   input  logic [W-1:0] cap_val,
   output logic [W-1:0] sr
);
   generate
      if (W == 1) begin : g_single
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)  sr <= '0;
            else if (cap) sr <= cap_val;
            else if (shf) sr <= tdi;
         end
      end else begin : g_multi
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)  sr <= '0;
            else if (cap) sr <= cap_val;
            else if (shf) sr <= {tdi, sr[W-1:1]};
         end
      end
   endgenerate
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
   import jtag_ir_pkg::*;
(
   input  logic [IR_W-1:0] ir,
   output ir_dec_t         dec
);
   always_comb begin
      dec = '{sel: SEL_BYPASS, pins_drive: 1'b0, core_drive: 1'b0,
              out_hiz: 1'b0, reload: 1'b0, flash_ok: 1'b0, fop: FOP_ERASE};
      case (ir)
         OP_PIN_DRIVE:  begin dec.sel = SEL_BOUNDARY; dec.pins_drive = 1'b1; end
         OP_PIN_SAMPLE: dec.sel = SEL_BOUNDARY;
         OP_CORE_TEST:  begin dec.sel = SEL_BOUNDARY; dec.core_drive = 1'b1; end
         OP_IDENT:      dec.sel = SEL_IDENT;
         OP_USER_WORD:  dec.sel = SEL_USER;
         OP_OUTS_OFF:   dec.out_hiz = 1'b1;
         OP_RELOAD:     dec.reload = 1'b1;
         OP_CFG_ENABLE: dec.sel = SEL_ISC_EN;
         OP_ERASE:      begin dec.sel = SEL_ISC_CFG; dec.flash_ok = 1'b1; dec.fop = FOP_ERASE;    end
         OP_BULK_ERASE: begin dec.sel = SEL_ISC_CFG; dec.flash_ok = 1'b1; dec.fop = FOP_BULK;     end
         OP_PROG:       begin dec.sel = SEL_ISC_CFG; dec.flash_ok = 1'b1; dec.fop = FOP_PROG;     end
         OP_VERIFY:     begin dec.sel = SEL_ISC_CFG; dec.flash_ok = 1'b1; dec.fop = FOP_VERIFY;   end
         OP_PROG_INC:   begin dec.sel = SEL_ISC_DAT; dec.flash_ok = 1'b1; dec.fop = FOP_PROG_INC; end
         OP_VERIFY_INC: begin dec.sel = SEL_ISC_DAT; dec.flash_ok = 1'b1; dec.fop = FOP_VER_INC;  end
         default:       dec.sel = SEL_BYPASS;
      endcase
   end
endmodule

// File: rtl/jtag_tdo_stage.sv
module jtag_tdo_stage (
   input  logic tck,
   input  logic trst_n,
   input  logic shift_ir,
   input  logic shift_dr,
   input  logic ir_bit,
   input  logic dr_bit,
   output logic tdo,
   output logic tdo_en
);
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= shift_ir | shift_dr;
         tdo    <= shift_ir ? ir_bit : (shift_dr ? dr_bit : 1'b0);
      end
   end
endmodule

// File: rtl/jtag_ir_dr_core.sv
module jtag_ir_dr_core
   import jtag_ir_pkg::*;
#(
   parameter int                ID_W       = 32,
   parameter logic [ID_W-1:0]   IDENT_WORD = 32'h2950_8093,
   parameter int                STAT_W     = 3,
   parameter int                EN_LEN     = 12,
   parameter int                CFG_LEN    = 27,
   parameter int                DAT_LEN    = 10
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tdi,
   input  logic               capture_ir,
   input  logic               shift_ir,
   input  logic               update_ir,
   input  logic               capture_dr,
   input  logic               shift_dr,
   input  logic               update_dr,
   input  logic [STAT_W-1:0]  isc_status,
   input  logic [ID_W-1:0]    usercode_i,
   input  logic               bsr_so,
   output logic               tdo,
   output logic               tdo_en,
   output logic               bsr_sel,
   output logic               pins_drive,
   output logic               core_drive,
   output logic               pins_hiz,
   output logic               cfg_reload,
   output logic               flash_go,
   output logic [2:0]         flash_op,
   output logic [EN_LEN-1:0]  isc_en_q,
   output logic [CFG_LEN-1:0] isc_cfg_q,
   output logic [DAT_LEN-1:0] isc_dat_q
);
   localparam int PAD_W = IR_W - STAT_W - 2;

   generate
      if (PAD_W < 0) begin : g_bad_stat
         $error("status field does not fit the instruction capture pattern");
      end
      if (EN_LEN < 1 || CFG_LEN < 1 || DAT_LEN < 1 || ID_W < 1) begin : g_bad_len
         $error("register lengths must be positive");
      end
   endgenerate

   logic [IR_W-1:0]    ir_q;
   logic [IR_W-1:0]    ir_sr;
   logic               byp_sr;
   logic [ID_W-1:0]    id_sr;
   logic [ID_W-1:0]    usr_sr;
   logic [EN_LEN-1:0]  en_sr;
   logic [CFG_LEN-1:0] cfg_sr;
   logic [DAT_LEN-1:0] dat_sr;
   ir_dec_t            dec;
   logic               dr_bit;
   logic [IR_W-1:0]    ir_cap;

   assign ir_cap = {{PAD_W{1'b0}}, isc_status, 2'b01};

   jtag_ir_decode u_dec (.ir(ir_q), .dec(dec));

   jtag_scan_chain #(.W(IR_W)) u_ir_chain (
      .tck, .trst_n, .cap(capture_ir), .shf(shift_ir), .tdi,
      .cap_val(ir_cap), .sr(ir_sr));

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        ir_q <= OP_IDENT;
      else if (update_ir) ir_q <= ir_sr;
   end

   jtag_scan_chain #(.W(1)) u_byp (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_BYPASS),
      .shf(shift_dr && dec.sel == SEL_BYPASS), .tdi, .cap_val(1'b0), .sr(byp_sr));

   jtag_scan_chain #(.W(ID_W)) u_ident (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_IDENT),
      .shf(shift_dr && dec.sel == SEL_IDENT), .tdi, .cap_val(IDENT_WORD), .sr(id_sr));

   jtag_scan_chain #(.W(ID_W)) u_user (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_USER),
      .shf(shift_dr && dec.sel == SEL_USER), .tdi, .cap_val(usercode_i), .sr(usr_sr));

   jtag_scan_chain #(.W(EN_LEN)) u_isc_en (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_ISC_EN),
      .shf(shift_dr && dec.sel == SEL_ISC_EN), .tdi, .cap_val(isc_en_q), .sr(en_sr));

   jtag_scan_chain #(.W(CFG_LEN)) u_isc_cfg (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_ISC_CFG),
      .shf(shift_dr && dec.sel == SEL_ISC_CFG), .tdi, .cap_val(isc_cfg_q), .sr(cfg_sr));

   jtag_scan_chain #(.W(DAT_LEN)) u_isc_dat (
      .tck, .trst_n, .cap(capture_dr && dec.sel == SEL_ISC_DAT),
      .shf(shift_dr && dec.sel == SEL_ISC_DAT), .tdi, .cap_val(isc_dat_q), .sr(dat_sr));

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         isc_en_q  <= '0;
         isc_cfg_q <= '0;
         isc_dat_q <= '0;
         flash_go  <= 1'b0;
         flash_op  <= 3'd0;
      end else begin
         flash_go <= update_dr & dec.flash_ok;
         if (update_dr) begin
            if (dec.sel == SEL_ISC_EN)  isc_en_q  <= en_sr;
            if (dec.sel == SEL_ISC_CFG) isc_cfg_q <= cfg_sr;
            if (dec.sel == SEL_ISC_DAT) isc_dat_q <= dat_sr;
            if (dec.flash_ok)           flash_op  <= dec.fop;
         end
      end
   end

   always_comb begin
      case (dec.sel)
         SEL_IDENT:    dr_bit = id_sr[0];
         SEL_USER:     dr_bit = usr_sr[0];
         SEL_BOUNDARY: dr_bit = bsr_so;
         SEL_ISC_EN:   dr_bit = en_sr[0];
         SEL_ISC_CFG:  dr_bit = cfg_sr[0];
         SEL_ISC_DAT:  dr_bit = dat_sr[0];
         default:      dr_bit = byp_sr;
      endcase
   end

   jtag_tdo_stage u_tdo (
      .tck, .trst_n, .shift_ir, .shift_dr, .ir_bit(ir_sr[0]), .dr_bit,
      .tdo, .tdo_en);

   assign bsr_sel    = (dec.sel == SEL_BOUNDARY);
   assign pins_drive = dec.pins_drive;
   assign core_drive = dec.core_drive;
   assign pins_hiz   = dec.out_hiz;
   assign cfg_reload = dec.reload;
endmodule

// File: rtl/jtag_ir_dr_chk.sv
module jtag_ir_dr_chk #(
   parameter int EN_LEN  = 12,
   parameter int CFG_LEN = 27,
   parameter int DAT_LEN = 10
) (
   input logic               tck,
   input logic               trst_n,
   input logic               capture_ir,
   input logic               update_ir,
   input logic               update_dr,
   input logic [7:0]         ir_q,
   input logic [7:0]         ir_sr,
   input logic               tdo,
   input logic               tdo_en,
   input logic               flash_go,
   input logic               pins_drive,
   input logic               core_drive,
   input logic               pins_hiz,
   input logic               cfg_reload,
   input logic [EN_LEN-1:0]  isc_en_q,
   input logic [CFG_LEN-1:0] isc_cfg_q,
   input logic [DAT_LEN-1:0] isc_dat_q
);
   // R2
   ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $past(capture_ir) |-> (ir_sr[1:0] == 2'b01 && ir_sr[7:5] == 3'b000));

   // R3
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !$past(update_ir) |-> $stable(ir_q));

   // R7
   hold_regs_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !$past(update_dr) |-> ($stable(isc_en_q) && $stable(isc_cfg_q) && $stable(isc_dat_q)));

   // R8
   flash_after_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
      flash_go |-> $past(update_dr));

   // R9
   modes_exclusive_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({pins_drive, core_drive, pins_hiz, cfg_reload}));

   // R11
   tdo_quiet_chk: assert property (@(negedge tck) disable iff (!trst_n)
      !tdo_en |-> !tdo);
endmodule

bind jtag_ir_dr_core jtag_ir_dr_chk #(.EN_LEN(EN_LEN), .CFG_LEN(CFG_LEN), .DAT_LEN(DAT_LEN)) u_chk (
   .tck(tck), .trst_n(trst_n), .capture_ir(capture_ir), .update_ir(update_ir),
   .update_dr(update_dr), .ir_q(ir_q), .ir_sr(ir_sr), .tdo(tdo), .tdo_en(tdo_en),
   .flash_go(flash_go), .pins_drive(pins_drive), .core_drive(core_drive),
   .pins_hiz(pins_hiz), .cfg_reload(cfg_reload), .isc_en_q(isc_en_q),
   .isc_cfg_q(isc_cfg_q), .isc_dat_q(isc_dat_q));

// File: tb/jtag_ir_dr_core_bench.sv
`timescale 1ns/1ps
module jtag_ir_dr_core_bench;
   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tdi = 1'b0;
   logic        capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
   logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic [2:0]  isc_status = 3'b000;
   logic [31:0] usercode_i = 32'h0;
   logic        bsr_so;
   logic        tdo, tdo_en, bsr_sel, pins_drive, core_drive, pins_hiz, cfg_reload;
   logic        flash_go;
   logic [2:0]  flash_op;
   logic [11:0] isc_en_q;
   logic [26:0] isc_cfg_q;
   logic [9:0]  isc_dat_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [11:0] en_m  = '0;
   logic [26:0] cfg_m = '0;
   logic [9:0]  dat_m = '0;

   always #2.5 tck = ~tck;
   assign bsr_so = ~tdi;

   jtag_ir_dr_core u_jtag_ir_dr_core (.*);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_known(input logic [7:0] op);
      case (op)
         8'h00, 8'h01, 8'h02, 8'hE8, 8'hEA, 8'hEB, 8'hEC, 8'hED,
         8'hEE, 8'hEF, 8'hF0, 8'hFC, 8'hFD, 8'hFE, 8'hFF: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int scan_len(input logic [7:0] op);
      case (op)
         8'hFE, 8'hFD: return 32;
         8'h00, 8'h01, 8'h02: return 4;
         8'hE8: return 12;
         8'hEA, 8'hEC, 8'hED, 8'hEE: return 27;
         8'hEB, 8'hEF: return 10;
         default: return 2;
      endcase
   endfunction

   function automatic int flash_code(input logic [7:0] op);
      case (op)
         8'hEC: return 0;
         8'hED: return 1;
         8'hEA: return 2;
         8'hEB: return 3;
         8'hEE: return 4;
         8'hEF: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [63:0] exp_capture(input logic [7:0] op, input logic [63:0] din);
      case (op)
         8'hFE: return 64'h2950_8093;
         8'hFD: return {32'h0, usercode_i};
         8'h00, 8'h01, 8'h02: return {60'h0, ~din[3:0]};
         8'hE8: return {52'h0, en_m};
         8'hEA, 8'hEC, 8'hED, 8'hEE: return {37'h0, cfg_m};
         8'hEB, 8'hEF: return {54'h0, dat_m};
         default: return {62'h0, din[0], 1'b0};
      endcase
   endfunction

   task automatic scan(input bit is_ir, input int len, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      if (is_ir) capture_ir = 1'b1; else capture_dr = 1'b1;
      @(posedge tck); #1;
      capture_ir = 1'b0; capture_dr = 1'b0;
      if (is_ir) shift_ir = 1'b1; else shift_dr = 1'b1;
      for (int i = 0; i < len; i++) begin
         tdi = din[i];
         @(negedge tck); #1;
         dout[i] = tdo;
         if (i == 0) check(tdo_en === 1'b1, "R11 tdo_en in shift", {63'h0, tdo_en}, 64'h1);
         @(posedge tck); #1;
         if (i == len - 1) check(tdo === dout[i], "R11 tdo held across rising edge", {63'h0, tdo}, {63'h0, dout[i]});
      end
      shift_ir = 1'b0; shift_dr = 1'b0;
      if (is_ir) update_ir = 1'b1; else update_dr = 1'b1;
      @(posedge tck); #1;
      update_ir = 1'b0; update_dr = 1'b0;
   endtask

   task automatic load_ir(input logic [7:0] op);
      logic [63:0] d;
      isc_status = 3'($urandom);
      scan(1'b1, 8, {56'h0, op}, d);
      check(d[7:0] === {3'b000, isc_status, 2'b01}, "R2 IR capture pattern", d, {56'h0, 3'b000, isc_status, 2'b01});
      check(pins_drive === (op == 8'h00) && core_drive === (op == 8'h02) &&
            pins_hiz === (op == 8'hFC) && cfg_reload === (op == 8'hF0),
            "R3 R9 mode decode", {60'h0, pins_drive, core_drive, pins_hiz, cfg_reload},
            {60'h0, op == 8'h00, op == 8'h02, op == 8'hFC, op == 8'hF0});
      check(bsr_sel === (op <= 8'h02), "R10 boundary select", {63'h0, bsr_sel}, {63'h0, op <= 8'h02});
      @(negedge tck); #1;
      check(tdo_en === 1'b0 && tdo === 1'b0, "R11 idle output", {62'h0, tdo_en, tdo}, 64'h0);
   endtask

   task automatic run_dr(input logic [7:0] op, input string req);
      logic [63:0] din, dout, exp, mask;
      int len;
      len = scan_len(op);
      din = {$urandom, $urandom};
      usercode_i = $urandom;
      exp = exp_capture(op, din);
      mask = (64'h1 << len) - 64'h1;
      scan(1'b0, len, din, dout);
      check((dout & mask) === (exp & mask), req, dout & mask, exp & mask);
      if (op == 8'hE8) en_m = din[11:0];
      if (scan_len(op) == 27) cfg_m = din[26:0];
      if (scan_len(op) == 10) dat_m = din[9:0];
      check(isc_en_q === en_m && isc_cfg_q === cfg_m && isc_dat_q === dat_m, "R7 hold registers",
            {15'h0, isc_en_q, isc_cfg_q, isc_dat_q}, {15'h0, en_m, cfg_m, dat_m});
      if (flash_code(op) >= 0)
         check(flash_go === 1'b1 && flash_op === 3'(flash_code(op)), "R8 flash strobe",
               {60'h0, flash_go, flash_op}, {60'h0, 1'b1, 3'(flash_code(op))});
      else
         check(flash_go === 1'b0, "R8 no flash strobe", {63'h0, flash_go}, 64'h0);
      @(posedge tck); #1;
      check(flash_go === 1'b0, "R8 strobe single cycle", {63'h0, flash_go}, 64'h0);
   endtask

   initial begin
      logic [63:0] d;
      logic [7:0] tbl [15] = '{8'h00, 8'h01, 8'h02, 8'hE8, 8'hEA, 8'hEB, 8'hEC, 8'hED,
                               8'hEE, 8'hEF, 8'hF0, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
      void'($urandom(32'h1234_5678));
      repeat (3) @(posedge tck);
      #1;
      check(tdo === 1'b0 && tdo_en === 1'b0 && flash_go === 1'b0, "R1 reset outputs",
            {61'h0, tdo, tdo_en, flash_go}, 64'h0);
      check(isc_en_q === '0 && isc_cfg_q === '0 && isc_dat_q === '0, "R1 reset holds",
            {15'h0, isc_en_q, isc_cfg_q, isc_dat_q}, 64'h0);
      trst_n = 1'b1;
      @(posedge tck); #1;
      scan(1'b0, 32, 64'h0, d);
      check(d[31:0] === 32'h2950_8093, "R1 R5 identification after reset", d, 64'h2950_8093);

      load_ir(8'hFC); run_dr(8'hFC, "R4 outputs-off uses bypass");
      load_ir(8'hF0); run_dr(8'hF0, "R4 reload uses bypass");
      load_ir(8'h55); run_dr(8'h55, "R4 unlisted opcode uses bypass");
      load_ir(8'hFD); run_dr(8'hFD, "R6 user word");
      load_ir(8'hEA); run_dr(8'hEA, "R7 R8 program path");
      run_dr(8'hEA, "R7 config readback");
      load_ir(8'hE8); run_dr(8'hE8, "R7 enable path");
      load_ir(8'hEF); run_dr(8'hEF, "R7 R8 data path");
      load_ir(8'h01); run_dr(8'h01, "R10 boundary route");

      for (int n = 0; n < 60; n++) begin
         logic [7:0] op;
         if ($urandom_range(0, 3) == 0) op = 8'($urandom);
         else op = tbl[$urandom_range(0, 14)];
         load_ir(op);
         run_dr(op, is_known(op) ? "R3 R5 R6 R7 R10 random scan" : "R4 random unlisted");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule